// File: doc/BRIEF.md
# Indexed Super-IO Configuration Port

This block holds the 256-entry byte-wide configuration file of an integrated Super-IO controller and gives a host access to it through two adjacent byte ports on an I/O bus. The first port (the index port) picks an entry. The second port (the data port) reads or writes the picked entry. Reading either port returns the picked entry. The read data is registered, so a read strobe in one cycle produces its byte in the next cycle.

Each entry has a write policy. Most of the low range and a scattered set of high entries are read-only. Two entries hold fixed serial-port base codes and take a write only when it carries exactly that code. The remaining high entries take any byte. A decode enable input comes from a bit in a host-bridge configuration byte. When that input is low, the port pair does not respond at all. Only the configuration storage and its access rules are built here. The serial, floppy and parallel functions that would read these entries are not part of the block.

Top module: `sio_cfg_port`

## Requirements
- R1: Reset (synchronous, active high) clears the index to 0x00 and sets read data to 0xFF. It loads entry 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. Every other entry becomes 0x00.
- R2: A write at the index port address (default 0x03F0) loads the index from the write data. Such a write never alters any entry.
- R3: A read strobe at the index port or at the data port (default 0x03F1), while enabled, puts the entry selected by the current index on the read data in the following cycle. In every other cycle the read data is 0xFF.
- R4: A data-port write is dropped when the index is in 0x00–0xDF, is one of 0xE4, 0xE5, 0xF3, 0xF5, 0xF7, or lies in 0xE9–0xED, 0xF9–0xFB or 0xFD–0xFF. These entries read 0x00.
- R5: At index 0xE7 a data-port write is stored only when the byte is 0xFE. Any other byte is dropped.
- R6: At index 0xE8 a data-port write is stored only when the byte is 0xBE. Any other byte is dropped.
- R7: Every other index (0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8, 0xFC) stores any byte written at the data port.
- R8: While the enable input is low, reads return 0xFF, writes to either port have no effect, and the index keeps its value.
- R9: Accesses at any other address are ignored. A read there returns 0xFF and a write changes neither the index nor any entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Decode enable, driven by a host-bridge configuration bit |
| bus_addr | input | ADDR_W (16) | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte, 0xFF when idle |

## Verification
A wrong index shows at the next read of either port as the byte of another entry, one cycle after the strobe. A wrong write filter shows the same way: either a read-only entry reads back the value just written, or an open entry keeps its old value. The sweep therefore writes a distinct byte to every index and reads it back through the other port right away, so any entry with the wrong policy is caught within two accesses. Faults in the enable gating and in the address decode show up as a non-0xFF read, or as a changed index on the next enabled read.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int CFG_DW      = 8;
    localparam int CFG_ENTRIES = 256;
    localparam int CFG_IW      = $clog2(CFG_ENTRIES);

    typedef logic [CFG_DW-1:0] cfg_byte_t;
    typedef logic [CFG_IW-1:0] cfg_idx_t;

    localparam cfg_byte_t IDLE_BYTE = 8'hFF;

    // Write policy class of an entry
    typedef enum logic [1:0] {
        ACC_LOCKED = 2'd0,
        ACC_OPEN   = 2'd1,
        ACC_KEYED  = 2'd2
    } acc_class_e;

    // Decoded bus request
    typedef struct packed {
        logic      sel_idx;
        logic      sel_dat;
        logic      wr;
        logic      rd;
        cfg_byte_t wdata;
    } port_req_t;

    function automatic acc_class_e acc_class(cfg_idx_t i);
        if (i inside {[8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3,
                      8'hF5, 8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]})
            return ACC_LOCKED;
        else if (i inside {8'hE7, 8'hE8})
            return ACC_KEYED;
        else
            return ACC_OPEN;
    endfunction

    // The single byte a keyed entry will take
    function automatic cfg_byte_t key_value(cfg_idx_t i);
        case (i)
            8'hE7:   return 8'hFE;
            8'hE8:   return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic cfg_byte_t reset_value(cfg_idx_t i);
        case (i)
            8'hE0:   return 8'h3C;
            8'hE2:   return 8'h03;
            8'hE3:   return 8'hFC;
            8'hE6:   return 8'hDE;
            8'hE7:   return 8'hFE;
            8'hE8:   return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h03F0
) (
    input  logic              port_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  cfg_byte_t         bus_wdata,
    output port_req_t         req
);
    localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_ADDR + 16'd1);

    always_comb begin
        req.sel_idx = port_en && (bus_addr == IDX_ADDR);
        req.sel_dat = port_en && (bus_addr == DAT_ADDR);
        req.wr      = bus_wr;
        req.rd      = bus_rd;
        req.wdata   = bus_wdata;
    end
endmodule

// File: rtl/sio_cfg_policy.sv
module sio_cfg_policy
    import sio_cfg_pkg::*;
(
    input  cfg_idx_t  idx,
    input  cfg_byte_t wdata,
    output logic      accept
);
    acc_class_e cls;

    always_comb begin
        cls = acc_class(idx);
        unique case (cls)
            ACC_OPEN:  accept = 1'b1;
            ACC_KEYED: accept = (wdata == key_value(idx));
            default:   accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
    import sio_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  cfg_idx_t  wr_idx,
    input  cfg_byte_t wdata,
    input  cfg_idx_t  rd_idx,
    output cfg_byte_t rd_val
);
    logic [CFG_ENTRIES*CFG_DW-1:0] flat;

    for (genvar g = 0; g < CFG_ENTRIES; g++) begin : g_ent
        localparam cfg_idx_t   IDX = cfg_idx_t'(g);
        localparam acc_class_e CLS = acc_class(IDX);
        if (CLS == ACC_LOCKED) begin : g_const
            // never writable: no storage, constant reset value
            assign flat[g*CFG_DW +: CFG_DW] = reset_value(IDX);
        end else begin : g_store
            cfg_byte_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reset_value(IDX);
                else if (we && (wr_idx == IDX))
                    q <= wdata;
            end
            assign flat[g*CFG_DW +: CFG_DW] = q;
        end
    end

    assign rd_val = flat[rd_idx*CFG_DW +: CFG_DW];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h03F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    port_req_t req;
    cfg_idx_t  cfg_index;
    cfg_byte_t sel_val;
    logic      accept;
    logic      data_we;

    sio_cfg_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .port_en  (port_en),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .req      (req)
    );

    sio_cfg_policy u_pol (
        .idx   (cfg_index),
        .wdata (req.wdata),
        .accept(accept)
    );

    assign data_we = req.wr && req.sel_dat && accept;

    sio_cfg_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (data_we),
        .wr_idx(cfg_index),
        .wdata (req.wdata),
        .rd_idx(cfg_index),
        .rd_val(sel_val)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cfg_index <= '0;
        else if (req.wr && req.sel_idx)
            cfg_index <= req.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= IDLE_BYTE;
        else if (req.rd && (req.sel_idx || req.sel_dat))
            bus_rdata <= sel_val;
        else
            bus_rdata <= IDLE_BYTE;
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h03F0
) (
    input logic              clk,
    input logic              rst,
    input logic              port_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        cfg_index
);
    localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(BASE_ADDR + 16'd1);

    logic port_hit;
    assign port_hit = port_en && ((bus_addr == A_IDX) || (bus_addr == A_DAT));

    assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
        (port_en && bus_wr && bus_addr == A_IDX) |=> (cfg_index == $past(bus_wdata)));

    assert_idle_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd) |=> (bus_rdata == 8'hFF));

    assert_locked_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && port_hit && acc_class(cfg_index) == ACC_LOCKED) |=> (bus_rdata == 8'h00));

    assert_key_e7_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && port_hit && cfg_index == 8'hE7) |=> (bus_rdata == 8'hFE));

    assert_key_e8_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && port_hit && cfg_index == 8'hE8) |=> (bus_rdata == 8'hBE));

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!port_en) |=> (bus_rdata == 8'hFF));

    assert_off_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!port_en) |=> $stable(cfg_index));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .port_en  (port_en),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cfg_index(cfg_index)
);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
    localparam logic [15:0] P_IDX = 16'h03F0;
    localparam logic [15:0] P_DAT = 16'h03F1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [256];

    always #10 clk = ~clk;

    sio_cfg_port u0 (
        .clk(clk), .rst(rst), .port_en(port_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] exp_default(int i);
        if (i == 'hE0) return 8'h3C;
        if (i == 'hE2) return 8'h03;
        if (i == 'hE3) return 8'hFC;
        if (i == 'hE6) return 8'hDE;
        if (i == 'hE7) return 8'hFE;
        if (i == 'hE8) return 8'hBE;
        return 8'h00;
    endfunction

    function automatic bit exp_ro(int i);
        return (i < 'hE0) || i == 'hE4 || i == 'hE5 || (i >= 'hE9 && i <= 'hED) ||
               i == 'hF3 || i == 'hF5 || i == 'hF7 ||
               (i >= 'hF9 && i <= 'hFB) || i >= 'hFD;
    endfunction

    function automatic bit exp_takes(int i, logic [7:0] v);
        if (exp_ro(i)) return 1'b0;
        if (i == 'hE7) return v == 8'hFE;
        if (i == 'hE8) return v == 8'hBE;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(logic [15:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) model[i] = exp_default(i);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic [7:0] v;
        do_reset();
        check(bus_rdata == 8'hFF, "R1", bus_rdata, 8'hFF);
        port_en = 1'b1;
        do_rd(P_DAT, got);   // index cleared to 0 by reset
        check(got == 8'h00, "R1", got, 8'h00);
        @(negedge clk);
        check(bus_rdata == 8'hFF, "R3", bus_rdata, 8'hFF);

        // full sweep: default, write a distinct byte, read back via index port
        for (int i = 0; i < 256; i++) begin
            do_wr(P_IDX, 8'(i));
            do_rd(P_DAT, got);
            check(got == model[i], "R1", got, model[i]);
            v = 8'(i) ^ 8'hA5;
            do_wr(P_DAT, v);
            if (exp_takes(i, v)) model[i] = v;
            do_rd(P_IDX, got);
            if (exp_ro(i))        check(got == model[i], "R4", got, model[i]);
            else if (i == 'hE7)   check(got == model[i], "R5", got, model[i]);
            else if (i == 'hE8)   check(got == model[i], "R6", got, model[i]);
            else                  check(got == model[i], "R7", got, model[i]);
        end

        // keyed entries: correct key, then a near-miss
        do_wr(P_IDX, 8'hE7); do_wr(P_DAT, 8'hFE); do_wr(P_DAT, 8'hFF);
        do_rd(P_DAT, got); check(got == 8'hFE, "R5", got, 8'hFE);
        do_wr(P_IDX, 8'hE8); do_wr(P_DAT, 8'hBE); do_wr(P_DAT, 8'h3E);
        do_rd(P_DAT, got); check(got == 8'hBE, "R6", got, 8'hBE);

        // index writes leave entries untouched
        do_wr(P_IDX, 8'hF0); do_wr(P_IDX, 8'h55); do_wr(P_IDX, 8'hF0);
        do_rd(P_DAT, got); check(got == model['hF0], "R2", got, model['hF0]);

        // other addresses ignored
        do_wr(P_IDX, 8'hE6);
        do_wr(16'h03F2, 8'hF1); do_wr(16'h03EF, 8'h77); do_wr(16'h13F1, 8'h12);
        do_rd(16'h03F2, got); check(got == 8'hFF, "R9", got, 8'hFF);
        do_rd(P_DAT, got); check(got == model['hE6], "R9", got, model['hE6]);

        // enable low: quiet, no writes, index held at E6
        port_en = 1'b0;
        do_wr(P_IDX, 8'hE0); do_wr(P_DAT, 8'h11);
        do_rd(P_DAT, got); check(got == 8'hFF, "R8", got, 8'hFF);
        do_rd(P_IDX, got); check(got == 8'hFF, "R8", got, 8'hFF);
        port_en = 1'b1;
        do_rd(P_DAT, got); check(got == model['hE6], "R8", got, model['hE6]);
        do_wr(P_IDX, 8'hE0);
        do_rd(P_DAT, got); check(got == model['hE0], "R8", got, model['hE0]);

        // reset again restores defaults over modified entries
        do_reset();
        for (int k = 'hE0; k <= 'hE8; k++) begin
            do_wr(P_IDX, 8'(k));
            do_rd(P_DAT, got);
            check(got == exp_default(k), "R1", got, exp_default(k));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule